// File: doc/BRIEF.md
# Programmable Parallel Pseudorandom Word Generator

This block generates a maximal-length pseudorandom bit pattern for link testing. It delivers the pattern as 16-bit parallel words, one full word on each enabled clock, ready for a serializer. A 3-bit select chooses one of five sequence lengths: 2^7-1, 2^10-1, 2^15-1, 2^23-1 or 2^31-1 bits. The polynomials follow the common telecom test-pattern recommendations.

All five sequences share one 31-bit state register. Each clock moves the sequence forward by sixteen bit positions. The sixteen feedback steps are unrolled into combinational logic, so the block never runs a serial shift register sixteen times. The state is reseeded with all ones in the bits the active polynomial uses. This happens on reset, on a seed strobe, and whenever the select value changes, so the register can never hold the all-zero state.

Top module: `prbs_word_gen`

## Requirements
- R1: While reset is high at a rising edge, the next cycle shows word_o = 0 and valid_o = 0, and the state is loaded with the all-ones seed of the selected mode.
- R2: len_sel_i picks the polynomial as follows:
  - 0 gives x^7+x^6+1.
  - 1 gives x^10+x^7+1.
  - 2 gives x^15+x^14+1.
  - 3 gives x^23+x^18+1.
  - 4 gives x^31+x^28+1.
- R3: Serial ordering rests on an equivalent serial generator with state s[n-1:0] and tap k. Each serial step emits b = s[n-1] ^ s[k-1] and then shifts to s = {s[n-2:0], b}. Word bit 15 carries the earliest bit. Successive words, concatenated, reproduce this serial stream exactly.
- R4: Each rising edge with en_i high and no reload advances the sequence by 16 positions. The new word is on word_o with valid_o = 1 in the following cycle.
- R5: A rising edge with en_i low holds word_o and the state, and drives valid_o to 0. The next enabled word continues the sequence without a gap.
- R6: A rising edge with seed_ld_i high reloads the all-ones seed and drives valid_o to 0. The next enabled word is then the first word of the sequence again.
- R7: A rising edge at which len_sel_i differs from its value at the previous edge reloads the seed of the new mode, with the same effect as R6.
- R8: Select values 5, 6 and 7 act as value 0 (the 2^7-1 sequence).
- R9: For the 7-, 10- and 15-bit modes, the word stream from a seed repeats after exactly 2^n-1 words, and no earlier word equals the first word.
- R10: The active state bits are never all zero, so in the 7-, 10- and 15-bit modes no valid word is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the pattern by one word |
| len_sel_i | input | 3 | Sequence length select (0..4; 5..7 map to 0) |
| seed_ld_i | input | 1 | Reload the all-ones seed |
| word_o | output | 16 | Pattern word, bit 15 first in serial order |
| valid_o | output | 1 | word_o holds a newly generated word |

## Verification
The assertions rely on three assumptions about the inputs:
- Reset is applied for at least one edge before any checking begins.
- len_sel_i, en_i and seed_ld_i are stable around the rising edge.
- A select change is an ordinary input transition, not a glitch.

The stimulus meets these assumptions by driving every input just after the falling edge. It keeps reset high for the first cycles and then never raises it again. It moves the select only between whole cycles, and it always does so in a cycle whose reload outcome the reference model also computes.

// File: rtl/prbs_pkg.sv
`timescale 1ns/1ps
package prbs_pkg;

   localparam int SEL_W     = 3;
   localparam int NUM_MODES = 5;
   localparam int MAX_ORDER = 31;

   typedef enum logic [SEL_W-1:0] {
      PAT7  = 3'd0,
      PAT10 = 3'd1,
      PAT15 = 3'd2,
      PAT23 = 3'd3,
      PAT31 = 3'd4
   } pat_e;

   // Polynomial degree for each mode index
   function automatic int order_of(input int m);
      case (m)
         0:       return 7;
         1:       return 10;
         2:       return 15;
         3:       return 23;
         default: return 31;
      endcase
   endfunction

   // Middle tap (x^k term) for each mode index
   function automatic int tap_of(input int m);
      case (m)
         0:       return 6;
         1:       return 7;
         2:       return 14;
         3:       return 18;
         default: return 28;
      endcase
   endfunction

endpackage

// File: rtl/prbs_step.sv
`timescale 1ns/1ps
// Unrolled feedback network: WORD_W serial steps computed in one cycle.
module prbs_step #(
   parameter int ORDER  = 7,
   parameter int TAP    = 6,
   parameter int WORD_W = 16
) (
   input  logic [ORDER-1:0]  cur_i,
   output logic [ORDER-1:0]  nxt_o,
   output logic [WORD_W-1:0] bits_o
);

   initial begin
      assert (ORDER >= 2) else $error("prbs_step: ORDER must be at least 2");
      assert (TAP >= 1 && TAP < ORDER) else $error("prbs_step: TAP out of range");
      assert (WORD_W >= 1) else $error("prbs_step: WORD_W must be positive");
   end

   always_comb begin
      logic [ORDER-1:0] s;
      logic             fb;
      s      = cur_i;
      bits_o = '0;
      for (int i = 0; i < WORD_W; i++) begin
         fb                  = s[ORDER-1] ^ s[TAP-1];
         bits_o[WORD_W-1-i]  = fb;
         s                   = {s[ORDER-2:0], fb};
      end
      nxt_o = s;
   end

endmodule

// File: rtl/prbs_mode_dec.sv
`timescale 1ns/1ps
// Maps the raw select to a mode and builds the matching all-ones seed.
module prbs_mode_dec
   import prbs_pkg::*;
#(
   parameter int STATE_W = 31
) (
   input  logic [SEL_W-1:0]   sel_i,
   output pat_e               mode_o,
   output logic [STATE_W-1:0] seed_o
);

   initial begin
      assert (STATE_W >= MAX_ORDER) else $error("prbs_mode_dec: STATE_W too small");
   end

   int active_order;

   always_comb begin
      if (sel_i < SEL_W'(NUM_MODES)) mode_o = pat_e'(sel_i);
      else                           mode_o = PAT7;
   end

   always_comb begin
      active_order = order_of(int'(mode_o));
      for (int b = 0; b < STATE_W; b++) begin
         seed_o[b] = (b < active_order);
      end
   end

endmodule

// File: rtl/prbs_seed_ctl.sv
`timescale 1ns/1ps
// Decides when the state must be reseeded: reset, strobe, or select change.
module prbs_seed_ctl #(
   parameter int SEL_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             seed_ld_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             load_o
);

   logic [SEL_W-1:0] sel_q;

   always_ff @(posedge clk_i) begin
      sel_q <= sel_i;
   end

   always_comb begin
      load_o = rst_i | seed_ld_i | (sel_i != sel_q);
   end

endmodule

// File: rtl/prbs_word_gen.sv
`timescale 1ns/1ps
module prbs_word_gen
   import prbs_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int STATE_W = 31
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              en_i,
   input  logic [SEL_W-1:0]  len_sel_i,
   input  logic              seed_ld_i,
   output logic [WORD_W-1:0] word_o,
   output logic              valid_o
);

   initial begin
      assert (STATE_W >= MAX_ORDER) else $error("prbs_word_gen: STATE_W below largest order");
      assert (WORD_W >= 1) else $error("prbs_word_gen: WORD_W must be positive");
   end

   pat_e               mode;
   logic [STATE_W-1:0] seed;
   logic               load;
   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] nxt_arr  [NUM_MODES];
   logic [WORD_W-1:0]  word_arr [NUM_MODES];
   logic [STATE_W-1:0] nxt_sel;
   logic [WORD_W-1:0]  word_sel;

   prbs_mode_dec #(.STATE_W(STATE_W)) u_dec (
      .sel_i  (len_sel_i),
      .mode_o (mode),
      .seed_o (seed)
   );

   prbs_seed_ctl #(.SEL_W(SEL_W)) u_ctl (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .seed_ld_i (seed_ld_i),
      .sel_i     (len_sel_i),
      .load_o    (load)
   );

   // One unrolled feedback network per selectable polynomial
   for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
      localparam int ORD = order_of(g);
      localparam int TP  = tap_of(g);
      logic [ORD-1:0] nxt_n;

      prbs_step #(.ORDER(ORD), .TAP(TP), .WORD_W(WORD_W)) u_step (
         .cur_i  (state_q[ORD-1:0]),
         .nxt_o  (nxt_n),
         .bits_o (word_arr[g])
      );

      always_comb begin
         nxt_arr[g]          = '0;
         nxt_arr[g][ORD-1:0] = nxt_n;
      end
   end

   always_comb begin
      nxt_sel  = nxt_arr[int'(mode)];
      word_sel = word_arr[int'(mode)];
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q <= seed;
         word_o  <= '0;
         valid_o <= 1'b0;
      end else if (load) begin
         state_q <= seed;
         valid_o <= 1'b0;
      end else if (en_i) begin
         state_q <= nxt_sel;
         word_o  <= word_sel;
         valid_o <= 1'b1;
      end else begin
         valid_o <= 1'b0;
      end
   end

   AST_NEVER_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      state_q != '0);                                                    // R10
   AST_LOAD_SEEDS: assert property (@(posedge clk_i) disable iff (rst_i)
      load |=> (state_q == $past(seed)));                                // R6
   AST_LOAD_DROPS_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
      load |=> !valid_o);                                                // R7
   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
      !en_i |=> (!valid_o && $stable(word_o)));                          // R5
   AST_ACTIVE_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
      (en_i && !load) |=> valid_o);                                      // R4

endmodule

// File: tb/sim_prbs_word_gen.sv
`timescale 1ns/1ps
module sim_prbs_word_gen;

   logic        clk = 1'b0;
   logic        rst, en, ld;
   logic [2:0]  sel;
   logic [15:0] word;
   logic        valid;

   always #10 clk = ~clk;   // 50 MHz

   prbs_word_gen u0 (
      .clk_i     (clk),
      .rst_i     (rst),
      .en_i      (en),
      .len_sel_i (sel),
      .seed_ld_i (ld),
      .word_o    (word),
      .valid_o   (valid)
   );

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 0;

   // Behavioural serial reference
   logic [30:0] ms;
   logic [15:0] mw;
   logic        mv;
   logic [2:0]  mprev;
   logic [15:0] p7 [4];

   function automatic int m_of(input logic [2:0] s);
      return (s > 3'd4) ? 0 : int'(s);
   endfunction
   function automatic int n_of(input int m);
      int t [5] = '{7, 10, 15, 23, 31};
      return t[m];
   endfunction
   function automatic int k_of(input int m);
      int t [5] = '{6, 7, 14, 18, 28};
      return t[m];
   endfunction
   function automatic logic [30:0] seed_of(input int m);
      logic [30:0] v = '0;
      for (int b = 0; b < n_of(m); b++) v[b] = 1'b1;
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic model_edge(input bit r, input bit e, input bit l, input logic [2:0] s);
      bit reload;
      int n, k;
      logic b;
      reload = r || l || (s != mprev);
      mprev  = s;
      n = n_of(m_of(s));
      k = k_of(m_of(s));
      if (r) begin
         ms = seed_of(m_of(s)); mw = '0; mv = 1'b0;
      end else if (reload) begin
         ms = seed_of(m_of(s)); mv = 1'b0;
      end else if (e) begin
         for (int i = 0; i < 16; i++) begin
            b = ms[n-1] ^ ms[k-1];
            mw[15-i] = b;
            ms = {ms[29:0], b} & seed_of(m_of(s));
         end
         mv = 1'b1;
      end else begin
         mv = 1'b0;
      end
   endtask

   task automatic cyc(input bit r, input bit e, input bit l, input logic [2:0] s,
                      input string req);
      rst = r; en = e; ld = l; sel = s;
      @(posedge clk);
      model_edge(r, e, l, s);
      @(negedge clk);
      check(word == mw, req, "word_o", 32'(word), 32'(mw));
      check(valid == mv, req, "valid_o", 32'(valid), 32'(mv));
   endtask

   task automatic period_run(input logic [2:0] s);
      int          p;
      int          early;
      logic [15:0] w0;
      bit          zero_seen;
      p = (1 << n_of(int'(s))) - 1;
      early = 0;
      zero_seen = 0;
      cyc(0, 0, 1, s, "R9");
      cyc(0, 1, 0, s, "R9");
      w0 = word;
      for (int i = 1; i < p; i++) begin
         cyc(0, 1, 0, s, "R9");
         if (word == w0) early++;
         if (word == 16'h0) zero_seen = 1;
      end
      cyc(0, 1, 0, s, "R9");
      check(early == 0, "R9", "early repeat count", 32'(early), 32'd0);
      check(word == w0, "R9", "word after full period", 32'(word), 32'(w0));
      check(!zero_seen, "R10", "all-zero word seen", 32'(zero_seen), 32'd0);
   endtask

   initial begin
      rst = 1; en = 0; ld = 0; sel = 3'd0;
      mprev = 3'd0; ms = '0; mw = '0; mv = 1'b0;
      // R1: reset state
      for (int i = 0; i < 3; i++) cyc(1, 1, 0, 3'd0, "R1");
      check(word == 16'h0 && valid == 1'b0, "R1", "reset outputs",
            {15'd0, valid, word}, 32'd0);
      // R2/R3: PRBS7 stream against serial model
      for (int i = 0; i < 40; i++) begin
         cyc(0, 1, 0, 3'd0, "R3");
         if (i < 4) p7[i] = word;
      end
      // R5: idle gaps hold output
      for (int i = 0; i < 30; i++) cyc(0, (i % 4) != 1 && (i % 4) != 2, 0, 3'd0, "R5");
      // R6: seed strobe restarts the sequence
      cyc(0, 1, 1, 3'd0, "R6");
      cyc(0, 1, 0, 3'd0, "R6");
      check(word == p7[0], "R6", "first word after seed", 32'(word), 32'(p7[0]));
      cyc(0, 1, 0, 3'd0, "R6");
      check(word == p7[1], "R6", "second word after seed", 32'(word), 32'(p7[1]));
      // R7/R2: every mode, entered by select change while enabled
      for (int m = 1; m < 5; m++) begin
         cyc(0, 1, 0, 3'(m), "R7");
         for (int i = 0; i < 60; i++) cyc(0, 1, 0, 3'(m), "R2");
      end
      // R8: values 5..7 behave as the 2^7-1 mode
      for (int s = 5; s < 8; s++) begin
         cyc(0, 1, 0, 3'(s), "R8");
         for (int i = 0; i < 4; i++) begin
            cyc(0, 1, 0, 3'(s), "R8");
            check(word == p7[i], "R8", "fallback word", 32'(word), 32'(p7[i]));
         end
      end
      // R9/R10: exact period for the short modes
      period_run(3'd0);
      period_run(3'd1);
      period_run(3'd2);
      // R4: long mode with irregular enable and occasional strobe
      cyc(0, 1, 0, 3'd4, "R4");
      for (int i = 0; i < 300; i++) cyc(0, (i % 3) != 0, (i % 97) == 50, 3'd4, "R4");
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(64'd20 * 64'd200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired: actual running expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule